// File: doc/BRIEF.md
# Priority Dual-Port Memory Arbiter

This block shares one single-ported memory between a host port and a network port. Network writes come from a receive path that cannot be paused, so they always have priority. Host accesses are handshaked: the host raises a request, holds it, and waits for an acknowledge. Each kind of access keeps the memory busy for a fixed number of clock cycles. On a 37.5 MHz clock a host write takes 9 cycles, while a host read and a network write take 5 cycles each.

Network writes that cannot start at once are kept in a small ordered queue, so none is lost. An accepted host request waits a short settle time before it competes for the memory, which gives the address decode time to become stable. To keep the host from being starved, the number of network writes that may start ahead of a waiting host request is limited. The first wait allows three. When the previous host access had to use its full allowance, the next wait allows two. Under sustained network load the memory then settles into a pattern of one host write between pairs of network writes.

Top module: `mem_port_arbiter`

## Requirements
- R1: An access keeps `mem_en` high for exactly 9 cycles for a host write, 5 for a host read and 5 for a network write. `mem_start` is high only in its first cycle, and `mem_we`, `mem_addr` and `mem_wdata` stay constant for the whole access. The next access may start in the cycle right after the last cycle of the previous one.
- R2: When the memory can start an access and both a queued network write and an eligible host request are present, the network write starts first, unless the host's pass allowance (R3) is used up.
- R3: While a host request is eligible, at most 3 network writes may start ahead of it. If the previous host access started only after its full allowance was used, the allowance for the next one is 2. Otherwise it is 3.
- R4: A host request is accepted on a rising edge of `host_req` while no host request is outstanding, with `host_we` = 1 meaning write. A rising edge while a request is outstanding is ignored. Each accepted request produces exactly one memory access and one acknowledge.
- R5: An accepted host request becomes eligible on the 5th clock edge after the edge that accepted it. If the memory is free, its access starts at that edge.
- R6: `host_ack` is a one-cycle pulse in the cycle after the last busy cycle of the host access. For a read, `host_rdata` carries the memory word sampled in that last cycle and holds it.
- R7: Each `net_wr_valid` strobe is queued, up to 8 pending writes. Its write starts at the earliest on the edge after the strobe edge. Network writes start in arrival order and write the address and data exactly as given.
- R8: During reset, `mem_en`, `mem_start` and `host_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with the acknowledge |
| net_wr_valid | input | 1 | One-cycle network write strobe |
| net_wr_addr | input | 16 | Network write address |
| net_wr_data | input | 32 | Network write data |
| mem_en | output | 1 | Memory busy with an access |
| mem_start | output | 1 | First cycle of an access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (combinational) |

## Verification
A wrong occupancy count shows up at once as an access that is too short or too long between two `mem_start` pulses, and it moves every later start and acknowledge. A corrupted pass counter or allowance flag makes a waiting host access start one network slot early or late, which can be seen at the host's `mem_start` within one network write time (5 cycles). A faulty queue pointer writes network data in the wrong order or to the wrong word, which a later host read of that address exposes. Broken host edge detection produces an extra or a missing acknowledge within about 15 cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_HOST_RD = 2'd1,
    SRC_HOST_WR = 2'd2,
    SRC_NET     = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_SETTLE = 2'd1,
    HS_WAIT   = 2'd2,
    HS_BUSY   = 2'd3
  } host_st_e;

  // busy cycles taken by one access of the given source
  function automatic int unsigned occ_len(src_e s, int unsigned hw, int unsigned hr,
                                          int unsigned nw);
    case (s)
      SRC_HOST_WR: return hw;
      SRC_HOST_RD: return hr;
      SRC_NET:     return nw;
      default:     return 0;
    endcase
  endfunction

  // network writes allowed ahead of a waiting host request
  function automatic int unsigned pass_limit(logic steady, int unsigned first,
                                             int unsigned later);
    return steady ? later : first;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/host_front.sv
module host_front import arb_pkg::*; #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              launch,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              ready,
  output logic              op_we,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata
);

  localparam int unsigned SC_W = $clog2(SETTLE_CYC + 1);

  host_st_e        st;
  logic [SC_W-1:0] settle_cnt;
  logic            req_q;
  logic            take;

  assign take  = (st == HS_IDLE) && host_req && !req_q;
  assign ready = (st == HS_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= HS_IDLE;
      settle_cnt <= '0;
      req_q      <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      op_we      <= 1'b0;
      op_addr    <= '0;
      op_wdata   <= '0;
    end else begin
      req_q    <= host_req;
      host_ack <= 1'b0;
      case (st)
        HS_IDLE: begin
          if (take) begin
            st         <= HS_SETTLE;
            settle_cnt <= SC_W'(SETTLE_CYC);
            op_we      <= host_we;
            op_addr    <= host_addr;
            op_wdata   <= host_wdata;
          end
        end
        HS_SETTLE: begin
          if (settle_cnt == SC_W'(1)) st <= HS_WAIT;
          else                        settle_cnt <= settle_cnt - SC_W'(1);
        end
        HS_WAIT: begin
          if (launch) st <= HS_BUSY;
        end
        HS_BUSY: begin
          if (done) begin
            st       <= HS_IDLE;
            host_ack <= 1'b1;
            if (!op_we) host_rdata <= rdata_in;
          end
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  // R6: acknowledge lasts one cycle
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R6: completion seen by the sequencer is acknowledged next cycle
  a_r6_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st == HS_BUSY) |=> host_ack);

  // R5: no access can begin while the settle time runs
  a_r5_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_SETTLE) |=> (st != HS_BUSY));

endmodule

// File: rtl/net_queue.sv
module net_queue #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic              full,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign valid     = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign head_addr = q_addr[rd_ptr];
  assign head_data = q_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= push_addr;
      q_data[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: a strobe never lands on a full queue unless a slot frees the same cycle
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  // R7: the arbiter only takes entries that exist
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid);

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter import arb_pkg::*; #(
  parameter int unsigned FIRST_PASS  = 3,
  parameter int unsigned STEADY_PASS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic can_launch,
  input  logic net_valid,
  input  logic host_ready,
  output logic net_launch,
  output logic host_launch,
  output logic [$clog2(((FIRST_PASS > STEADY_PASS) ? FIRST_PASS : STEADY_PASS) + 1)-1:0] pass_cnt
);

  localparam int unsigned MAXP  = (FIRST_PASS > STEADY_PASS) ? FIRST_PASS : STEADY_PASS;
  localparam int unsigned CNT_W = $clog2(MAXP + 1);

  logic             steady;
  logic [CNT_W-1:0] limit;
  logic             net_first;

  assign limit       = CNT_W'(pass_limit(steady, FIRST_PASS, STEADY_PASS));
  assign net_first   = net_valid && (!host_ready || (pass_cnt < limit));
  assign net_launch  = can_launch && net_first;
  assign host_launch = can_launch && host_ready && !net_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_cnt <= '0;
      steady   <= 1'b0;
    end else if (host_launch) begin
      pass_cnt <= '0;
      steady   <= (pass_cnt == limit);
    end else if (net_launch && host_ready) begin
      pass_cnt <= pass_cnt + CNT_W'(1);
    end
  end

  // R3: the counted passes never exceed the allowance in force
  a_r3_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pass_cnt <= limit);

  // R1: at most one source wins a slot
  a_r1_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    !(net_launch && host_launch));

endmodule

// File: rtl/mem_sequencer.sv
module mem_sequencer import arb_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HW_CYC = 9,
  parameter int unsigned HR_CYC = 5,
  parameter int unsigned NW_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  src_e              launch_src,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_data,
  output logic              can_launch,
  output logic              host_done,
  output src_e              cur_src,
  output logic              mem_en,
  output logic              mem_start,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int unsigned MAXC  = max3(HW_CYC, HR_CYC, NW_CYC);
  localparam int unsigned OCC_W = $clog2(MAXC + 1);

  logic [OCC_W-1:0] occ;

  assign can_launch = (occ <= OCC_W'(1));
  assign mem_en     = (occ != '0);
  assign host_done  = (occ == OCC_W'(1)) &&
                      ((cur_src == SRC_HOST_RD) || (cur_src == SRC_HOST_WR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ       <= '0;
      cur_src   <= SRC_NONE;
      mem_start <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_start <= launch;
      if (launch) begin
        occ       <= OCC_W'(occ_len(launch_src, HW_CYC, HR_CYC, NW_CYC));
        cur_src   <= launch_src;
        mem_we    <= (launch_src != SRC_HOST_RD);
        mem_addr  <= launch_addr;
        mem_wdata <= launch_data;
      end else if (occ != '0) begin
        occ <= occ - OCC_W'(1);
        if (occ == OCC_W'(1)) cur_src <= SRC_NONE;
      end
    end
  end

  // R1: attributes hold for the whole access
  a_r1_attr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_start) |-> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R1: a new access is only issued when the running one ends
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> can_launch);

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter import arb_pkg::*; #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned HW_CYC      = 9,
  parameter int unsigned HR_CYC      = 5,
  parameter int unsigned NW_CYC      = 5,
  parameter int unsigned SETTLE_CYC  = 4,
  parameter int unsigned FIRST_PASS  = 3,
  parameter int unsigned STEADY_PASS = 2,
  parameter int unsigned NQ_DEPTH    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              net_wr_valid,
  input  logic [ADDR_W-1:0] net_wr_addr,
  input  logic [DATA_W-1:0] net_wr_data,
  output logic              mem_en,
  output logic              mem_start,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned MAXP  = (FIRST_PASS > STEADY_PASS) ? FIRST_PASS : STEADY_PASS;
  localparam int unsigned PC_W  = $clog2(MAXP + 1);

  // named internal events
  logic              h_ready, h_we;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              nq_valid, nq_full;
  logic [ADDR_W-1:0] nq_addr;
  logic [DATA_W-1:0] nq_data;
  logic              can_launch, host_done;
  logic              net_launch, host_launch, launch;
  logic [PC_W-1:0]   pass_cnt;
  src_e              cur_src, l_src;
  logic [ADDR_W-1:0] l_addr;
  logic [DATA_W-1:0] l_data;

  host_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .launch(host_launch), .done(host_done), .rdata_in(mem_rdata),
    .ready(h_ready), .op_we(h_we), .op_addr(h_addr), .op_wdata(h_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata)
  );

  net_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(NQ_DEPTH)) u_nq (
    .clk(clk), .rst_n(rst_n),
    .push(net_wr_valid), .push_addr(net_wr_addr), .push_data(net_wr_data),
    .pop(net_launch), .valid(nq_valid), .full(nq_full),
    .head_addr(nq_addr), .head_data(nq_data)
  );

  slot_arbiter #(.FIRST_PASS(FIRST_PASS), .STEADY_PASS(STEADY_PASS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .can_launch(can_launch), .net_valid(nq_valid), .host_ready(h_ready),
    .net_launch(net_launch), .host_launch(host_launch), .pass_cnt(pass_cnt)
  );

  always_comb begin
    if (net_launch) begin
      l_src  = SRC_NET;
      l_addr = nq_addr;
      l_data = nq_data;
    end else begin
      l_src  = h_we ? SRC_HOST_WR : SRC_HOST_RD;
      l_addr = h_addr;
      l_data = h_wdata;
    end
  end

  assign launch = net_launch | host_launch;

  mem_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .HW_CYC(HW_CYC), .HR_CYC(HR_CYC), .NW_CYC(NW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_src(l_src), .launch_addr(l_addr), .launch_data(l_data),
    .can_launch(can_launch), .host_done(host_done), .cur_src(cur_src),
    .mem_en(mem_en), .mem_start(mem_start), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R2: with a queued network write and no passes counted, the network takes the free slot
  a_r2_net_first: assert property (@(posedge clk) disable iff (!rst_n)
    (nq_valid && can_launch && pass_cnt == '0) |=> (cur_src == SRC_NET));

  // R7: the queue state flag is consistent with the launch decision
  a_r7_full_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (nq_full && can_launch && !h_ready) |-> net_launch);

endmodule

// File: tb/test_mem_port_arbiter.sv
module test_mem_port_arbiter;

  localparam int HW = 9, HR = 5, NW = 5, SETTLE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        net_wr_valid = 1'b0;
  logic [15:0] net_wr_addr = '0;
  logic [31:0] net_wr_data = '0;
  logic        mem_en, mem_start, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  mem_port_arbiter i_mem_port_arbiter (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .net_wr_valid(net_wr_valid), .net_wr_addr(net_wr_addr), .net_wr_data(net_wr_data),
    .mem_en(mem_en), .mem_start(mem_start), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem_model [256];
  always @(posedge clk) if (mem_start && mem_we) mem_model[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem_model[mem_addr[7:0]];

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // access log: launch edge, address, write flag
  int          st_edge [1024];
  logic [15:0] st_addr [1024];
  logic        st_we   [1024];
  int          n_st = 0;
  int          run_len = 0;
  int          run_kind = 0;   // 1 host write, 2 host read, 3 network write
  int          ack_total = 0;

  function automatic int exp_len(int kind);
    return (kind == 1) ? HW : (kind == 2) ? HR : NW;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (host_ack) ack_total++;
      if (mem_start) begin
        if (run_len > 0) check(run_len == exp_len(run_kind), "R1", "back-to-back access length",
                               run_len, exp_len(run_kind));
        if (n_st < 1024) begin
          st_edge[n_st] = cyc; st_addr[n_st] = mem_addr; st_we[n_st] = mem_we; n_st++;
        end
        run_kind = !mem_we ? 2 : (mem_addr[15:12] == 4'h2) ? 3 : 1;
        run_len  = 1;
      end else if (mem_en) begin
        run_len++;
      end else if (run_len > 0) begin
        check(run_len == exp_len(run_kind), "R1", "access length", run_len, exp_len(run_kind));
        run_len = 0;
      end
    end
  end

  function automatic bit is_host(int i);
    return !st_we[i] || (st_addr[i][15:12] != 4'h2);
  endfunction

  function automatic int host_after(int from);
    for (int i = from; i < n_st; i++) if (is_host(i)) return i;
    return -1;
  endfunction

  task automatic host_op(input bit we, input logic [15:0] a, input logic [31:0] d,
                         output int req_e, output int ack_e);
    bit got;
    @(negedge clk);
    host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
    req_e = cyc + 1;
    got = 1'b0;
    ack_e = -1;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (host_ack) begin got = 1'b1; ack_e = cyc; end
    end
    host_req = 1'b0;
    check(got, "R6", "acknowledge arrived", 32'(got), 1);
    @(negedge clk);
    check(!host_ack, "R6", "acknowledge is one cycle", 32'(host_ack), 0);
  endtask

  task automatic net_burst(input int lead, input logic [15:0] base, input int n, input int gap);
    repeat (lead) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      net_wr_valid = 1'b1; net_wr_addr = base + 16'(i); net_wr_data = 32'hC0DE_0000 | 32'(base + 16'(i));
      @(negedge clk);
      net_wr_valid = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!mem_en, "R8", "mem_en in reset", 32'(mem_en), 0);
    check(!mem_start, "R8", "mem_start in reset", 32'(mem_start), 0);
    check(!host_ack, "R8", "host_ack in reset", 32'(host_ack), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // idle memory: settle latency, write then read back
  task automatic t_idle_host;
    int rq, ak, b, h;
    b = n_st;
    host_op(1'b1, 16'h1010, 32'h5A5A_1234, rq, ak);
    h = host_after(b);
    check(h >= 0 && st_edge[h] == rq + SETTLE + 1, "R5", "idle host write start", st_edge[h], rq + SETTLE + 1);
    check(ak == st_edge[h] + HW, "R6", "host write ack edge", ak, st_edge[h] + HW);
    check(st_we[h] && st_addr[h] == 16'h1010, "R4", "host write address", st_addr[h], 16'h1010);
    repeat (3) @(negedge clk);
    b = n_st;
    host_op(1'b0, 16'h1010, 32'h0, rq, ak);
    h = host_after(b);
    check(h >= 0 && st_edge[h] == rq + SETTLE + 1, "R5", "idle host read start", st_edge[h], rq + SETTLE + 1);
    check(ak == st_edge[h] + HR, "R6", "host read ack edge", ak, st_edge[h] + HR);
    check(host_rdata == 32'h5A5A_1234, "R6", "read data", host_rdata, 32'h5A5A_1234);
  endtask

  // saturated network against a waiting host write; allowance given by expect_pass
  task automatic t_contend(input logic [15:0] hbase, input logic [15:0] nbase, input int nwr,
                           input int expect_pass, input string req);
    int rq, ak, b, h, passes, nets;
    logic [15:0] nxt;
    b = n_st;
    fork
      host_op(1'b1, hbase, 32'hB0B0_0000 | 32'(hbase), rq, ak);
      net_burst(1, nbase, nwr, NW);
    join
    repeat (40) @(negedge clk);
    h = host_after(b);
    passes = 0; nets = 0; nxt = nbase;
    for (int i = b; i < n_st; i++) begin
      if (!is_host(i)) begin
        check(st_addr[i] == nxt, "R7", "network arrival order", st_addr[i], nxt);
        nxt++; nets++;
        if (i < h && st_edge[i] >= rq + SETTLE + 1) passes++;
      end
    end
    check(nets == nwr, "R7", "no network write lost", nets, nwr);
    check(st_edge[b] == rq + 2, "R2", "network first when both present", st_edge[b], rq + 2);
    check(passes == expect_pass, req, "network passes before host", passes, expect_pass);
    check(h >= 0 && st_edge[h] == rq + 2 + (expect_pass + 1) * NW, req, "host start edge",
          st_edge[h], rq + 2 + (expect_pass + 1) * NW);
    check(ak == st_edge[h] + HW, "R6", "ack after contended write", ak, st_edge[h] + HW);
  endtask

  task automatic t_readback;
    int rq, ak;
    host_op(1'b0, 16'h1020, 32'h0, rq, ak);
    check(host_rdata == 32'hB0B0_1020, "R4", "host write data landed", host_rdata, 32'hB0B0_1020);
    host_op(1'b0, 16'h2003, 32'h0, rq, ak);
    check(host_rdata == 32'hC0DE_2003, "R7", "network data landed", host_rdata, 32'hC0DE_2003);
    host_op(1'b0, 16'h2045, 32'h0, rq, ak);
    check(host_rdata == 32'hC0DE_2045, "R7", "queued network data landed", host_rdata, 32'hC0DE_2045);
  endtask

  // rising edge while busy is refused
  task automatic t_refuse;
    int b, rq, acks0, hosts;
    b = n_st; acks0 = ack_total;
    @(negedge clk);
    host_we = 1'b0; host_addr = 16'h1010; host_req = 1'b1;
    rq = cyc + 1;
    repeat (3) @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    host_req = 1'b1;
    repeat (40) @(negedge clk);
    hosts = 0;
    for (int i = b; i < n_st; i++) if (is_host(i)) hosts++;
    check(hosts == 1, "R4", "single access for re-raised request", hosts, 1);
    check(ack_total - acks0 == 1, "R4", "single acknowledge", ack_total - acks0, 1);
    check(n_st > b && st_edge[b] == rq + SETTLE + 1, "R5", "refuse test start", st_edge[b], rq + SETTLE + 1);
    host_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_host();
    t_contend(16'h1020, 16'h2000, 6, 3, "R3");
    repeat (10) @(negedge clk);
    t_contend(16'h1030, 16'h2040, 8, 2, "R3");
    t_readback();
    t_refuse();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL all watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule